// File: doc/BRIEF.md
# Hold-Register Cartridge Memory Mapper

This block sits on an 8-bit CPU bus in front of a memory that holds three 2 KB RAM banks and one 2 KB ROM bank. The CPU sees a 4 KB window, selected by address bit 12, which is split into a lower and an upper 2 KB half. Each half points at one of the four banks. The bank pair comes from a small configuration register.

The CPU cannot write RAM through the data bus. Instead it touches an address in the first 256 bytes of the window, whose low eight bits become the byte to store. This loads a hold register and arms a write. Five distinct bus accesses later, the access that lands in the window stores the held byte at its own location, if writing is enabled. Touching the window offset 0xFF8 moves the hold register into the configuration register.

Every bus cycle is presented as a valid/ready transfer on `bus_valid`/`bus_ready`. Cycles outside the window are also presented, because they count toward the write timing. The block has no other back-pressure. `bus_ready` is low only while the RAM banks are being zeroed after reset. After that, one access is accepted every cycle in which `bus_valid` is high. For each accepted access inside the window, `rsp_valid` pulses exactly one cycle later together with `rsp_data`. Nothing can stall the response.

The backing memory port answers a read one cycle after `mem_en`.

Top module: `hold_reg_mapper`

## Requirements
- R1: After reset, `bus_ready` stays low while words 0..6143 (RAM banks 0–2) are written with zero through the memory port. When `bus_ready` rises, `cfg_state` is 0 and `rom_power_on` is 1.
- R2: For an accepted access with `bus_addr[12]`=1, `rsp_valid` is high in the next cycle and `rsp_data` is the byte at bank×2048 + `bus_addr[10:0]`. The lower half is used when `bus_addr[11]`=0 and the upper half otherwise. Accesses with `bus_addr[12]`=0 produce no response.
- R3: The 3-bit pair select maps to (lower bank, upper bank), with bank 3 being ROM: 0→(2,3), 1→(0,3), 2→(2,0), 3→(0,2), 4→(2,3), 5→(1,3), 6→(2,1), 7→(1,2).
- R4: A window access with `bus_addr[11:8]`=0 loads `bus_addr[7:0]` into the hold register, arms a write and restarts the access count. This happens only when writing is disabled or no write is armed.
- R5: An access at window offset 0xFF8 (bus address 0x1FF8) loads `cfg_state` with hold[4:0] and disarms any armed write.
- R6: Configuration field layout: bit 0 turns the ROM off when 1 (`rom_power_on` = not bit 0), bit 1 is write enable, and bits 4..2 are the pair select. Hold bits 7..5 are discarded.
- R7: With writing enabled, an armed write commits on the window access that is the fifth distinct access after the arming access. The held byte is stored at that access's mapped location, `rsp_data` returns the stored byte, and the write disarms.
- R8: An access whose address equals the previous accepted access does not advance the count. A window access before the fifth distinct one stores nothing and leaves the write armed.
- R9: Once more than five distinct accesses have passed since arming, the armed write is cancelled and the sixth access stores nothing.
- R10: A commit aimed at an upper half that maps the ROM bank stores nothing, but it still disarms the write.
- R11: While writing is enabled and a write is armed, an access with `bus_addr[11:8]`=0 is treated as a commit candidate, not a new latch.
- R12: Back-pressure: an access is taken only when `bus_valid` and `bus_ready` are both high, and `bus_ready` is high at all times except during the post-reset clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is presented |
| bus_ready | output | 1 | Block accepts the bus cycle |
| bus_addr | input | 13 | Bus address; bit 12 selects the cartridge window |
| rsp_valid | output | 1 | Read data valid, one cycle after a window access |
| rsp_data | output | 8 | Read data, or the byte just stored |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 13 | Memory byte address: bank × 2048 + offset |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_en` |
| cfg_state | output | 5 | Current configuration (pair select, write enable, ROM off) |
| rom_power_on | output | 1 | High while the ROM is powered |

## Verification
The dangerous internal state is the armed flag and the distinct-access count, and neither appears on a pin. A count that is off by one shows up only at the commit access. There, the stored byte either lands one access early or late, or is missing. It can be seen on `rsp_data` in that same response, or on the next read of that location. A stale armed flag shows up later, when an intended latch in the first 256 bytes is taken as a commit instead. Wrong pair decoding shows up in the very next response from the affected half. The bench therefore reads back each location right after each commit window, and it walks all eight pair codes with a marker byte in every bank.

// File: rtl/hrm_pkg.sv
package hrm_pkg;

  localparam int CFG_W = 5;
  localparam logic [1:0] ROM_BANK = 2'd3;

  typedef struct packed {
    logic [2:0] pair_sel;
    logic       wr_en;
    logic       rom_off;
  } cfg_t;

  typedef struct packed {
    logic [1:0] lo;
    logic [1:0] hi;
  } bank_pair_t;

  function automatic bank_pair_t pair_lookup(input logic [2:0] sel);
    bank_pair_t p;
    case (sel)
      3'd0:    p = '{lo: 2'd2, hi: 2'd3};
      3'd1:    p = '{lo: 2'd0, hi: 2'd3};
      3'd2:    p = '{lo: 2'd2, hi: 2'd0};
      3'd3:    p = '{lo: 2'd0, hi: 2'd2};
      3'd4:    p = '{lo: 2'd2, hi: 2'd3};
      3'd5:    p = '{lo: 2'd1, hi: 2'd3};
      3'd6:    p = '{lo: 2'd2, hi: 2'd1};
      default: p = '{lo: 2'd1, hi: 2'd2};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hrm_clear.sv
module hrm_clear #(
  parameter int MEM_AW    = 13,
  parameter int RAM_WORDS = 6144
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              busy_o,
  output logic [MEM_AW-1:0] addr_o
);
  localparam logic [MEM_AW-1:0] LAST = MEM_AW'(RAM_WORDS - 1);

  logic [MEM_AW-1:0] cnt;
  logic              busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign busy_o = busy;
  assign addr_o = cnt;

  // R1: the sweep stops exactly after the last RAM word
  p_clear_stops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST) |=> (!busy && $stable(cnt)));

  // R1: the sweep never walks into the ROM bank
  p_clear_in_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));

endmodule

// File: rtl/hrm_tracker.sv
module hrm_tracker #(
  parameter int GAP = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       distinct,
  input  logic       cart,
  input  logic       latch_zone,
  input  logic       hot_hit,
  input  logic       wen,
  input  logic [7:0] addr_lo,
  output logic [7:0] hold_o,
  output logic       pending_o,
  output logic       do_latch,
  output logic       do_hot,
  output logic       do_commit
);
  localparam int DMAX = GAP + 1;
  localparam int DW   = $clog2(DMAX + 1);
  localparam logic [DW-1:0] DSAT = DW'(DMAX);
  localparam logic [DW-1:0] DGAP = DW'(GAP);

  logic [7:0]    hold;
  logic          pending;
  logic [DW-1:0] delta, delta_now;
  logic          pend_live;

  // saturating count of distinct accesses since arming
  assign delta_now = (delta == DSAT) ? DSAT : delta + DW'(distinct);
  assign pend_live = pending && (delta_now <= DGAP);

  assign do_latch  = acc && latch_zone && (!wen || !pend_live);
  assign do_hot    = acc && !do_latch && hot_hit;
  assign do_commit = acc && !do_latch && !do_hot && cart && wen &&
                     pend_live && (delta_now == DGAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold    <= '0;
      pending <= 1'b0;
      delta   <= '0;
    end else if (acc) begin
      if (do_latch) begin
        hold    <= addr_lo;
        pending <= 1'b1;
        delta   <= '0;
      end else begin
        pending <= (do_hot || do_commit) ? 1'b0 : pend_live;
        delta   <= delta_now;
      end
    end
  end

  assign hold_o    = hold;
  assign pending_o = pending;

  // R4: a latch arms and captures the low address byte
  p_latch_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_latch |=> (pending && hold == $past(addr_lo)));

  // R5: the configuration hotspot disarms
  p_hot_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_hot |=> !pending);

  // R7: a commit disarms and keeps the held byte
  p_commit_disarms_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_commit |=> (!pending && $stable(hold)));

  // R9: passing the window without a commit cancels
  p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pending && !do_latch && delta == DGAP && distinct) |=> !pending);

  // R8: a repeated address leaves the count unchanged
  p_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !distinct && !do_latch) |=> $stable(delta));

endmodule

// File: rtl/hrm_xlate.sv
module hrm_xlate
  import hrm_pkg::*;
#(
  parameter int BANK_AW = 11
) (
  input  cfg_t               cfg,
  input  logic [BANK_AW:0]   off,
  output logic [BANK_AW+1:0] mem_addr,
  output logic               into_rom
);
  bank_pair_t pair;
  logic [1:0] bank_of [2];
  logic [1:0] sel_bank;

  assign pair = pair_lookup(cfg.pair_sel);

  for (genvar h = 0; h < 2; h++) begin : g_half
    if (h == 0) begin : g_lo
      assign bank_of[h] = pair.lo;
    end else begin : g_hi
      assign bank_of[h] = pair.hi;
    end
  end

  assign sel_bank = bank_of[off[BANK_AW]];
  assign mem_addr = {sel_bank, off[BANK_AW-1:0]};
  assign into_rom = (sel_bank == ROM_BANK);

endmodule

// File: rtl/hold_reg_mapper.sv
module hold_reg_mapper
  import hrm_pkg::*;
#(
  parameter int BANK_AW   = 11,
  parameter int GAP       = 5,
  parameter int RAM_BANKS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  output logic               bus_ready,
  input  logic [BANK_AW+1:0] bus_addr,
  output logic               rsp_valid,
  output logic [7:0]         rsp_data,
  output logic               mem_en,
  output logic               mem_we,
  output logic [BANK_AW+1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  output logic [CFG_W-1:0]   cfg_state,
  output logic               rom_power_on
);
  localparam int WIN_AW    = BANK_AW + 1;
  localparam int ADDR_W    = WIN_AW + 1;
  localparam int MEM_AW    = BANK_AW + 2;
  localparam int RAM_WORDS = RAM_BANKS << BANK_AW;
  localparam logic [WIN_AW-1:0] HOT_OFF = WIN_AW'((1 << WIN_AW) - 8);

  logic              clearing;
  logic [MEM_AW-1:0] clr_addr;
  logic              acc, cart, distinct, latch_zone, hot_hit;
  logic [WIN_AW-1:0] off;
  logic [ADDR_W-1:0] prev_addr;
  logic              prev_vld;
  cfg_t              cfg;
  logic [7:0]        hold;
  logic              pending;
  logic              do_latch, do_hot, do_commit, write_ok;
  logic [MEM_AW-1:0] map_addr;
  logic              into_rom;
  logic              rsp_q, wrote_q;
  logic [7:0]        wdat_q;

  hrm_clear #(.MEM_AW(MEM_AW), .RAM_WORDS(RAM_WORDS)) u_clear (
    .clk(clk), .rst_n(rst_n), .busy_o(clearing), .addr_o(clr_addr)
  );

  assign bus_ready  = !clearing;
  assign acc        = bus_valid && bus_ready;
  assign cart       = bus_addr[WIN_AW];
  assign off        = bus_addr[WIN_AW-1:0];
  assign distinct   = !prev_vld || (bus_addr != prev_addr);
  assign latch_zone = cart && (off[WIN_AW-1:8] == '0);
  assign hot_hit    = cart && (off == HOT_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      prev_vld  <= 1'b0;
    end else if (acc) begin
      prev_addr <= bus_addr;
      prev_vld  <= 1'b1;
    end
  end

  hrm_tracker #(.GAP(GAP)) u_track (
    .clk(clk), .rst_n(rst_n), .acc(acc), .distinct(distinct), .cart(cart),
    .latch_zone(latch_zone), .hot_hit(hot_hit), .wen(cfg.wr_en),
    .addr_lo(bus_addr[7:0]), .hold_o(hold), .pending_o(pending),
    .do_latch(do_latch), .do_hot(do_hot), .do_commit(do_commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (do_hot) cfg <= cfg_t'(hold[CFG_W-1:0]);
  end

  hrm_xlate #(.BANK_AW(BANK_AW)) u_xlate (
    .cfg(cfg), .off(off), .mem_addr(map_addr), .into_rom(into_rom)
  );

  assign write_ok  = do_commit && !into_rom;
  assign mem_en    = clearing || (acc && cart);
  assign mem_we    = clearing || write_ok;
  assign mem_addr  = clearing ? clr_addr : map_addr;
  assign mem_wdata = clearing ? 8'h00 : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q   <= 1'b0;
      wrote_q <= 1'b0;
      wdat_q  <= '0;
    end else begin
      rsp_q   <= acc && cart;
      wrote_q <= write_ok;
      wdat_q  <= hold;
    end
  end

  assign rsp_valid    = rsp_q;
  assign rsp_data     = wrote_q ? wdat_q : mem_rdata;
  assign cfg_state    = cfg;
  assign rom_power_on = !cfg.rom_off;

  // R2: a response follows exactly one accepted window access
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && bus_ready && bus_addr[WIN_AW]));

  // R5: the configuration takes the held low bits
  p_cfg_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    do_hot |=> (cfg_state == $past(hold[CFG_W-1:0])));

  // R10: the ROM bank never receives a bus-side store
  p_rom_safe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !clearing) |-> (mem_addr[MEM_AW-1:MEM_AW-2] != ROM_BANK));

  // R6: no store happens while writing is disabled
  p_wen_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !clearing) |-> cfg.wr_en);

  // R12: nothing is taken during the clear
  p_no_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> !rsp_valid || $past(!clearing));

endmodule

// File: tb/tb_hold_reg_mapper.sv
module tb_hold_reg_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic [12:0] bus_addr = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        mem_en, mem_we;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [4:0]  cfg_state;
  logic        rom_power_on;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  hold_reg_mapper dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cfg_state(cfg_state),
    .rom_power_on(rom_power_on)
  );

  // backing memory model: one-cycle read latency
  logic [7:0] bmem [0:8191];
  logic [7:0] brd = '0;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      brd <= bmem[mem_addr];
    end
  end
  assign mem_rdata = brd;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [12:0] a, output logic v, output logic [7:0] d);
    bus_addr  = a;
    bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0;
    v = rsp_valid;
    d = rsp_data;
  endtask

  function automatic logic [31:0] vec(input int r, input bit c,
                                      input logic [12:0] a, input logic [7:0] e);
    return {r[7:0], c, 2'b00, a, e};
  endfunction

  localparam int NV = 54;
  localparam logic [31:0] VEC [NV] = '{
    vec(2, 1, 13'h1800, 8'hA5),   // R2 ROM byte, upper half
    vec(1, 1, 13'h1234, 8'h00),   // R1 cleared RAM
    vec(2, 0, 13'h0050, 8'h00),   // R2 outside window: no response
    vec(4, 1, 13'h100E, 8'h00),   // R4 latch 0x0E
    vec(5, 1, 13'h1FF8, 8'h5D),   // R5 hotspot, old map read
    vec(4, 1, 13'h105A, 8'h00),   // R4 arm 0x5A
    vec(8, 0, 13'h0080, 8'h00),
    vec(8, 0, 13'h0081, 8'h00),
    vec(8, 0, 13'h0082, 8'h00),
    vec(8, 0, 13'h0083, 8'h00),
    vec(7, 1, 13'h1123, 8'h5A),   // R7 fifth distinct: commit
    vec(7, 1, 13'h1123, 8'h5A),   // R7 read back bank 0
    vec(3, 1, 13'h1923, 8'h00),   // R3 upper is bank 2
    vec(4, 1, 13'h1077, 8'h00),   // R9 arm 0x77
    vec(9, 0, 13'h0080, 8'h00),
    vec(9, 0, 13'h0081, 8'h00),
    vec(9, 0, 13'h0082, 8'h00),
    vec(9, 0, 13'h0083, 8'h00),
    vec(9, 0, 13'h0084, 8'h00),
    vec(9, 1, 13'h1124, 8'h00),   // R9 sixth: cancelled
    vec(9, 1, 13'h1124, 8'h00),   // R9 nothing stored
    vec(4, 1, 13'h1033, 8'h00),   // R8 arm 0x33
    vec(8, 0, 13'h0080, 8'h00),
    vec(8, 0, 13'h0081, 8'h00),
    vec(8, 0, 13'h0082, 8'h00),
    vec(8, 1, 13'h1125, 8'h00),   // R8 fourth: too early
    vec(8, 1, 13'h1125, 8'h00),   // R8 repeat does not count
    vec(7, 1, 13'h1126, 8'h33),   // R7 fifth distinct: commit
    vec(8, 1, 13'h1125, 8'h00),   // R8 early access stored nothing
    vec(7, 1, 13'h1126, 8'h33),
    vec(4, 1, 13'h1044, 8'h00),   // R11 arm 0x44
    vec(11, 0, 13'h0080, 8'h00),
    vec(11, 0, 13'h0081, 8'h00),
    vec(11, 0, 13'h0082, 8'h00),
    vec(11, 0, 13'h0083, 8'h00),
    vec(11, 1, 13'h1010, 8'h44),  // R11 latch-zone address commits
    vec(3, 1, 13'h1810, 8'h00),   // R3 upper bank 2 untouched
    vec(4, 1, 13'h1066, 8'h00),   // R7 arm 0x66
    vec(7, 0, 13'h0080, 8'h00),
    vec(7, 0, 13'h0081, 8'h00),
    vec(7, 0, 13'h0082, 8'h00),
    vec(7, 0, 13'h0083, 8'h00),
    vec(7, 1, 13'h1A00, 8'h66),   // R7 commit into upper half
    vec(2, 1, 13'h1A00, 8'h66),
    vec(4, 1, 13'h1002, 8'h00),   // R4 latch 0x02
    vec(5, 1, 13'h1FF8, 8'h00),   // R5 now (2,ROM), writes on
    vec(4, 1, 13'h1099, 8'h00),   // R10 arm 0x99
    vec(10, 0, 13'h0080, 8'h00),
    vec(10, 0, 13'h0081, 8'h00),
    vec(10, 0, 13'h0082, 8'h00),
    vec(10, 0, 13'h0083, 8'h00),
    vec(10, 1, 13'h1900, 8'hA5),  // R10 commit to ROM suppressed
    vec(10, 1, 13'h1900, 8'hA5),  // R10 ROM unchanged
    vec(3, 1, 13'h1200, 8'h66)    // R3 lower is bank 2
  };

  localparam logic [1:0] EXP_LO [8] = '{2'd2, 2'd0, 2'd2, 2'd0, 2'd2, 2'd1, 2'd2, 2'd1};
  localparam logic [1:0] EXP_HI [8] = '{2'd3, 2'd3, 2'd0, 2'd2, 2'd3, 2'd3, 2'd1, 2'd2};

  task automatic wait_ready(output int n);
    n = 0;
    while (!bus_ready && n < 7000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    logic v;
    logic [7:0] d;
    int n;
    for (int i = 0; i < 6144; i++) bmem[i] = 8'hEE;
    for (int i = 0; i < 2048; i++) bmem[6144 + i] = i[7:0] ^ 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(bus_ready == 1'b0, "R12 ready low during clear", bus_ready, 0);
    wait_ready(n);
    check(bus_ready == 1'b1, "R1 clear finishes", bus_ready, 1);
    check(n >= 6100, "R1 clear sweeps all RAM words", n, 6143);
    check(cfg_state == 5'h00, "R1 reset configuration", cfg_state, 0);
    check(rom_power_on == 1'b1, "R1 ROM powered after reset", rom_power_on, 1);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] e;
      e = VEC[i];
      access(e[20:8], v, d);
      if (e[23]) begin
        checks++;
        if (!(v && d == e[7:0])) begin
          failures++;
          $display("FAIL R%0d row %0d addr=0x%0h actual=%0b/0x%0h expected=1/0x%0h",
                   e[31:24], i, e[20:8], v, d, e[7:0]);
        end
      end else begin
        check(!v, $sformatf("R%0d row %0d no response", e[31:24], i), v, 0);
      end
    end
    check(cfg_state == 5'h02, "R6 write-enable configuration", cfg_state, 2);
    check(rom_power_on == 1'b1, "R6 ROM power bit clear", rom_power_on, 1);

    // R6: bits 7..5 of the hold are dropped
    access(13'h10FF, v, d);
    access(13'h1FF8, v, d);
    check(cfg_state == 5'h1F, "R6 upper hold bits dropped", cfg_state, 5'h1F);
    check(rom_power_on == 1'b0, "R6 ROM powered off", rom_power_on, 0);

    // R3: walk every pair code with a marker in each bank
    for (int b = 0; b < 4; b++) bmem[b*2048 + 16'h7F0] = 8'h10 + b[7:0];
    for (int c = 0; c < 8; c++) begin
      logic [7:0] cb;
      cb = {3'b000, c[2:0], 2'b01};
      access({5'b10000, cb}, v, d);
      access(13'h1FF8, v, d);
      check(cfg_state == cb[4:0], "R5 pair code loaded", cfg_state, cb[4:0]);
      access(13'h17F0, v, d);
      check(v && d == 8'h10 + EXP_LO[c], $sformatf("R3 code %0d lower", c), d, 8'h10 + EXP_LO[c]);
      access(13'h1FF0, v, d);
      check(v && d == 8'h10 + EXP_HI[c], $sformatf("R3 code %0d upper", c), d, 8'h10 + EXP_HI[c]);
    end

    // R1: reset in mid-run re-clears RAM and restores the configuration
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(bus_ready == 1'b0, "R12 ready low after second reset", bus_ready, 0);
    wait_ready(n);
    check(cfg_state == 5'h00 && rom_power_on, "R1 configuration after reset", cfg_state, 0);
    access(13'h17F0, v, d);
    check(v && d == 8'h00, "R1 bank 2 marker cleared", d, 0);
    access(13'h1FF0, v, d);
    check(v && d == 8'h13, "R1 ROM kept across reset", d, 8'h13);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule